// File: doc/BRIEF.md
# Bus Slave Window Decoder

This block is the slave-side front end of a board that occupies a 512-byte window on an asynchronous, strobe-based system bus. The address strobe, the two byte-lane data strobes, the read/write line, the address and the write data come from the bus master. They are brought into a local clock domain through two-flop synchronizers. When a slave cycle starts, the block captures the low address bits and holds them. When the window matches, it raises a board-enable flag. It then routes the access to one of three targets: a DMA controller register bank, an 8-bit talker/listener controller, or a pair of write-only 8-bit configuration registers.

For the two controllers, the block produces the chip selects, register selects and byte-lane information. It also returns their read data to the master. It holds the configuration registers itself. It produces an active-low acknowledge one local clock after the selection is made, and holds it until the master drops its data strobes. Board enable persists past the acknowledge and is released only when the bus is fully quiet. An override input forces the talker/listener register select to the auxiliary-mode register and turns the access into a write.

Top module: `vsd_bus_slave`

## Requirements
- R1: While reset is high, and after it until the first slave cycle, `ack_n` is 1, `brd_en`, `dma_cs` and `tlc_cs` are 0, and both configuration registers read 0x00. Reset also clears configuration registers that were written before it.
- R2: The address is captured when a cycle starts, which requires the address strobe to be low and the acknowledge released. The captured value stays unchanged for the rest of the cycle, even if `addr` changes while `brd_en` is high.
- R3: `brd_en` rises only when `addr[14:8]` (A15..A9) equals `WIN_BASE` and at least one data strobe is low. An access outside the window never raises `brd_en` and gets no acknowledge.
- R4: With A8 (`addr[7]`) = 0, `dma_cs` is set. `dma_reg` carries A7..A1 (`addr[6:0]`), and `dma_lanes` carries the active-high data strobes, with bit 0 for the low byte. A read returns `dma_rdata` on `dat_o`. At most one target select is active at a time.
- R5: With A8 = 1, A4 (`addr[3]`) = 1 and the low-byte strobe `ds_n[0]` low, `tlc_cs` is set and `tlc_rs` carries A3..A1 (`addr[2:0]`). A read returns 0xFF in the upper byte and `tlc_rdata` in the lower byte.
- R6: The override `aux_force` is sampled each clock. One clock later, `tlc_rs` equals `AUX_RS` (default 5) and `tlc_wr` is 1. Without the override, `tlc_wr` follows the cycle's write flag.
- R7: With A8 = 1 and A4 = 0, a write with `ds_n[0]` low loads `dat_i[7:0]` into `cfg1` if A2 (`addr[1]`) = 0, or into `cfg2` if A2 = 1. A write with only the upper strobe low is acknowledged and changes neither register.
- R8: A read of either configuration register is acknowledged, returns 0xFFFF, and leaves both registers unchanged.
- R9: `ack_n` falls exactly one clock after a target select rises. It stays low while any data strobe remains low, and rises within a few clocks after both are released. It is never low without a select.
- R10: An in-window access that selects no target, such as a talker/listener address with only the upper strobe low, raises `brd_en` but never an acknowledge.
- R11: `brd_en` stays high after the acknowledge ends. It falls only after both data strobes and the address strobe are high and `ack_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| as_n | input | 1 | Bus address strobe, active low, asynchronous |
| ds_n | input | 2 | Data strobes, active low; bit 0 low byte, bit 1 high byte |
| wr_n | input | 1 | Bus write line, low for a write |
| addr | input | 15 | Bus address A15..A1 (bit i is A(i+1)) |
| dat_i | input | 16 | Write data from the master |
| dat_o | output | 16 | Read data to the master; 0xFFFF when not acknowledging a read |
| ack_n | output | 1 | Data acknowledge, active low |
| aux_force | input | 1 | Override: force auxiliary register select and write |
| brd_en | output | 1 | Board enable |
| dma_cs | output | 1 | DMA controller select |
| dma_reg | output | 7 | DMA register address A7..A1 |
| dma_lanes | output | 2 | DMA byte lanes, active high |
| dma_wr | output | 1 | Cycle is a write (DMA controller) |
| dma_rdata | input | 16 | DMA controller read data |
| tlc_cs | output | 1 | Talker/listener controller select |
| tlc_rs | output | 3 | Talker/listener register select |
| tlc_wr | output | 1 | Talker/listener write strobe level |
| tlc_rdata | input | 8 | Talker/listener read data |
| cfg1 | output | 8 | Configuration register 1 contents |
| cfg2 | output | 8 | Configuration register 2 contents |

## Verification
The bound checker watches, on every clock, the rules that involve only local state. These are: at most one select at a time, the acknowledge landing one clock after a select rises, no acknowledge without a select, the captured address staying frozen while the board is enabled, the override reaching the register-select lines one clock later, configuration contents changing only on an acknowledge edge, and board enable falling only with the acknowledge released. The bench scenarios show the rest, which depends on what the master does at the pins. That covers the returned data per target, the upper-byte fill, which register a write lands in, the bus-timeout cases where no acknowledge ever comes, and the order in which board enable is released against strobes held by the master.

// File: rtl/vsd_pkg.sv
package vsd_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DMA  = 2'd1,
    TGT_TLC  = 2'd2,
    TGT_CFG  = 2'd3
  } tgt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEL  = 2'd1,
    ST_ACK  = 2'd2,
    ST_WAIT = 2'd3
  } cyc_st_e;
endpackage

// File: rtl/vsd_sync.sv
module vsd_sync #(
  parameter int W        = 1,
  parameter bit RST_ONES = 1'b0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] RV = RST_ONES ? {W{1'b1}} : {W{1'b0}};

  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= RV;
      q    <= RV;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/vsd_target_dec.sv
module vsd_target_dec
  import vsd_pkg::*;
#(
  parameter int ADDR_W = 15
) (
  input  logic [ADDR_W-1:0] a_i,
  input  logic [1:0]        ds_i,
  output tgt_e              tgt_o,
  output logic              cfg_idx_o
);
  // a_i[k] carries address line A(k+1)
  localparam int A8 = 7;
  localparam int A4 = 3;
  localparam int A2 = 1;

  always_comb begin
    cfg_idx_o = a_i[A2];
    if (!a_i[A8])
      tgt_o = TGT_DMA;
    else if (a_i[A4])
      tgt_o = ds_i[0] ? TGT_TLC : TGT_NONE;
    else
      tgt_o = TGT_CFG;
  end
endmodule

// File: rtl/vsd_cfg_bank.sv
module vsd_cfg_bank #(
  parameter int N  = 2,
  parameter int DW = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [N-1:0]         we,
  input  logic [DW-1:0]        wd,
  output logic [N-1:0][DW-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst)        q[i] <= '0;
      else if (we[i]) q[i] <= wd;
    end
  end
endmodule

// File: rtl/vsd_bus_slave.sv
module vsd_bus_slave
  import vsd_pkg::*;
#(
  parameter int          ADDR_W   = 15,
  parameter int          DW       = 16,
  parameter int          DMA_RW   = 7,
  parameter int          TLC_RW   = 3,
  parameter logic [6:0]  WIN_BASE = 7'h2C,
  parameter logic [2:0]  AUX_RS   = 3'd5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              as_n,
  input  logic [1:0]        ds_n,
  input  logic              wr_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     dat_i,
  output logic [DW-1:0]     dat_o,
  output logic              ack_n,
  input  logic              aux_force,
  output logic              brd_en,
  output logic              dma_cs,
  output logic [DMA_RW-1:0] dma_reg,
  output logic [1:0]        dma_lanes,
  output logic              dma_wr,
  input  logic [DW-1:0]     dma_rdata,
  output logic              tlc_cs,
  output logic [TLC_RW-1:0] tlc_rs,
  output logic              tlc_wr,
  input  logic [DW/2-1:0]   tlc_rdata,
  output logic [DW/2-1:0]   cfg1,
  output logic [DW/2-1:0]   cfg2
);
  localparam int BW     = DW / 2;
  localparam int WIN_LO = 8;
  localparam int N_CFG  = 2;

  // synchronized bus inputs
  logic [3:0]        strb_s;
  logic              as_s, wr_s;
  logic [1:0]        ds_s;
  logic [ADDR_W-1:0] a_s;
  logic [DW-1:0]     d_s;

  vsd_sync #(.W(4), .RST_ONES(1'b1)) u_sync_strb (
    .clk(clk), .rst(rst), .d({as_n, ds_n, wr_n}), .q(strb_s));
  vsd_sync #(.W(ADDR_W + DW), .RST_ONES(1'b0)) u_sync_data (
    .clk(clk), .rst(rst), .d({addr, dat_i}), .q({a_s, d_s}));

  assign as_s = ~strb_s[3];
  assign ds_s = ~strb_s[2:1];
  assign wr_s = ~strb_s[0];

  logic ds_any, in_win;
  assign ds_any = |ds_s;
  assign in_win = (a_s[ADDR_W-1:WIN_LO] == WIN_BASE[ADDR_W-WIN_LO-1:0]);

  tgt_e dec_tgt;
  logic dec_idx;
  vsd_target_dec #(.ADDR_W(ADDR_W)) u_dec (
    .a_i(a_s), .ds_i(ds_s), .tgt_o(dec_tgt), .cfg_idx_o(dec_idx));

  // cycle state
  cyc_st_e           st;
  logic [ADDR_W-1:0] hold_a;
  logic [1:0]        lanes_q;
  logic              wr_q, cidx_q, ack_q, cfg_hit;
  tgt_e              tgt_q;

  logic [N_CFG-1:0]         cfg_we;
  logic [N_CFG-1:0][BW-1:0] cfg_q;

  always_comb begin
    cfg_we = '0;
    if (st == ST_SEL && tgt_q == TGT_CFG && wr_q && lanes_q[0])
      cfg_we[cidx_q] = 1'b1;
  end

  vsd_cfg_bank #(.N(N_CFG), .DW(BW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wd(d_s[BW-1:0]), .q(cfg_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      hold_a  <= '0;
      lanes_q <= '0;
      wr_q    <= 1'b0;
      cidx_q  <= 1'b0;
      tgt_q   <= TGT_NONE;
      brd_en  <= 1'b0;
      dma_cs  <= 1'b0;
      tlc_cs  <= 1'b0;
      cfg_hit <= 1'b0;
      ack_q   <= 1'b0;
      dat_o   <= '1;
    end else begin
      unique case (st)
        ST_IDLE: begin
          if (as_s) begin
            hold_a  <= a_s;
            lanes_q <= ds_s;
            wr_q    <= wr_s;
          end
          if (as_s && ds_any && in_win) begin
            st      <= ST_SEL;
            brd_en  <= 1'b1;
            tgt_q   <= dec_tgt;
            cidx_q  <= dec_idx;
            dma_cs  <= (dec_tgt == TGT_DMA);
            tlc_cs  <= (dec_tgt == TGT_TLC);
            cfg_hit <= (dec_tgt == TGT_CFG);
          end
        end
        ST_SEL: begin
          if (tgt_q == TGT_NONE) begin
            st <= ST_WAIT;
          end else begin
            st    <= ST_ACK;
            ack_q <= 1'b1;
            if (!wr_q) begin
              unique case (tgt_q)
                TGT_DMA: dat_o <= dma_rdata;
                TGT_TLC: dat_o <= {{BW{1'b1}}, tlc_rdata};
                default: dat_o <= '1;
              endcase
            end
          end
        end
        ST_ACK: begin
          if (!ds_any) begin
            st      <= ST_WAIT;
            ack_q   <= 1'b0;
            dma_cs  <= 1'b0;
            tlc_cs  <= 1'b0;
            cfg_hit <= 1'b0;
            dat_o   <= '1;
          end
        end
        ST_WAIT: begin
          if (!as_s && !ds_any) begin
            st     <= ST_IDLE;
            brd_en <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // talker/listener select lines with override
  always_ff @(posedge clk) begin
    if (rst) begin
      tlc_rs <= '0;
      tlc_wr <= 1'b0;
    end else begin
      tlc_rs <= aux_force ? AUX_RS[TLC_RW-1:0] : hold_a[TLC_RW-1:0];
      tlc_wr <= aux_force | wr_q;
    end
  end

  assign ack_n     = ~ack_q;
  assign dma_reg   = hold_a[DMA_RW-1:0];
  assign dma_lanes = lanes_q;
  assign dma_wr    = wr_q;
  assign cfg1      = cfg_q[0];
  assign cfg2      = cfg_q[1];
endmodule

// File: rtl/vsd_bus_slave_chk.sv
module vsd_bus_slave_chk #(
  parameter int         DMA_RW = 7,
  parameter int         TLC_RW = 3,
  parameter int         BW     = 8,
  parameter logic [2:0] AUX_RS = 3'd5
) (
  input logic              clk,
  input logic              rst,
  input logic              ack_n,
  input logic              brd_en,
  input logic              dma_cs,
  input logic              tlc_cs,
  input logic              cfg_hit,
  input logic [DMA_RW-1:0] dma_reg,
  input logic [TLC_RW-1:0] tlc_rs,
  input logic              tlc_wr,
  input logic              aux_force,
  input logic [BW-1:0]     cfg1,
  input logic [BW-1:0]     cfg2
);
  p_sel_onehot_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dma_cs, tlc_cs, cfg_hit}));

  p_sel_in_board_r3: assert property (@(posedge clk) disable iff (rst)
    (dma_cs || tlc_cs || cfg_hit) |-> brd_en);

  p_ack_lat_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(dma_cs || tlc_cs || cfg_hit) |=> !ack_n);

  p_ack_needs_sel_r9: assert property (@(posedge clk) disable iff (rst)
    !ack_n |-> (brd_en && (dma_cs || tlc_cs || cfg_hit)));

  p_addr_held_r2: assert property (@(posedge clk) disable iff (rst)
    (brd_en && $past(brd_en)) |-> $stable(dma_reg));

  p_aux_force_r6: assert property (@(posedge clk) disable iff (rst)
    aux_force |=> (tlc_rs == AUX_RS[TLC_RW-1:0] && tlc_wr));

  p_cfg1_on_ack_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg1) |-> $fell(ack_n));

  p_cfg2_on_ack_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(cfg2) |-> $fell(ack_n));

  p_brd_release_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(brd_en) |-> (ack_n && $past(ack_n)));
endmodule

bind vsd_bus_slave vsd_bus_slave_chk #(
  .DMA_RW(DMA_RW), .TLC_RW(TLC_RW), .BW(DW/2), .AUX_RS(AUX_RS)
) u_chk (
  .clk(clk), .rst(rst), .ack_n(ack_n), .brd_en(brd_en),
  .dma_cs(dma_cs), .tlc_cs(tlc_cs), .cfg_hit(cfg_hit),
  .dma_reg(dma_reg), .tlc_rs(tlc_rs), .tlc_wr(tlc_wr),
  .aux_force(aux_force), .cfg1(cfg1), .cfg2(cfg2)
);

// File: tb/sim_vsd_bus_slave.sv
`timescale 1ns/1ps
module sim_vsd_bus_slave;
  localparam logic [6:0]  BASE    = 7'h2C;
  localparam logic [15:0] DMA_RD  = 16'hA5C3;
  localparam logic [7:0]  TLC_RD  = 8'h3C;

  typedef struct packed {
    logic [14:0] a;
    logic [1:0]  ds;     // active high, bit0 = low byte
    logic        wr;
    logic [15:0] wd;
    logic        e_brd;
    logic        e_ack;
    logic [1:0]  e_sel;  // 0 none, 1 dma, 2 tlc, 3 cfg
    logic [15:0] e_rd;
    logic [7:0]  e_c1;
    logic [7:0]  e_c2;
  } vec_t;

  localparam vec_t TAB [10] = '{
    '{{BASE, 8'h12}, 2'b11, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd1, DMA_RD,   8'h00, 8'h00},
    '{{BASE, 8'h8D}, 2'b01, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 16'hFF3C, 8'h00, 8'h00},
    '{{BASE, 8'h8D}, 2'b11, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd2, 16'hFF3C, 8'h00, 8'h00},
    '{{BASE, 8'h8D}, 2'b10, 1'b0, 16'h0000, 1'b1, 1'b0, 2'd0, 16'hFFFF, 8'h00, 8'h00},
    '{{BASE, 8'h80}, 2'b11, 1'b1, 16'h125A, 1'b1, 1'b1, 2'd3, 16'hFFFF, 8'h5A, 8'h00},
    '{{BASE, 8'h82}, 2'b01, 1'b1, 16'h00C7, 1'b1, 1'b1, 2'd3, 16'hFFFF, 8'h5A, 8'hC7},
    '{{BASE, 8'h80}, 2'b11, 1'b0, 16'h0000, 1'b1, 1'b1, 2'd3, 16'hFFFF, 8'h5A, 8'hC7},
    '{{7'h2D, 8'h12}, 2'b11, 1'b0, 16'h0000, 1'b0, 1'b0, 2'd0, 16'hFFFF, 8'h5A, 8'hC7},
    '{{BASE, 8'h82}, 2'b10, 1'b1, 16'h9900, 1'b1, 1'b1, 2'd3, 16'hFFFF, 8'h5A, 8'hC7},
    '{{BASE, 8'h40}, 2'b01, 1'b1, 16'h0077, 1'b1, 1'b1, 2'd1, 16'hFFFF, 8'h5A, 8'hC7}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        as_n = 1'b1;
  logic [1:0]  ds_n = 2'b11;
  logic        wr_n = 1'b1;
  logic [14:0] addr = '0;
  logic [15:0] dat_i = '0;
  logic        aux_force = 1'b0;
  logic [15:0] dat_o;
  logic        ack_n, brd_en, dma_cs, dma_wr, tlc_cs, tlc_wr;
  logic [6:0]  dma_reg;
  logic [1:0]  dma_lanes;
  logic [2:0]  tlc_rs;
  logic [7:0]  cfg1, cfg2;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  vsd_bus_slave u0 (
    .clk(clk), .rst(rst), .as_n(as_n), .ds_n(ds_n), .wr_n(wr_n),
    .addr(addr), .dat_i(dat_i), .dat_o(dat_o), .ack_n(ack_n),
    .aux_force(aux_force), .brd_en(brd_en), .dma_cs(dma_cs),
    .dma_reg(dma_reg), .dma_lanes(dma_lanes), .dma_wr(dma_wr),
    .dma_rdata(DMA_RD), .tlc_cs(tlc_cs), .tlc_rs(tlc_rs),
    .tlc_wr(tlc_wr), .tlc_rdata(TLC_RD), .cfg1(cfg1), .cfg2(cfg2)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // start a cycle, poll for the acknowledge; reports what was seen
  task automatic start_cyc(input logic [14:0] a, input logic [1:0] ds, input logic wr,
                           input logic [15:0] wd, output logic got_ack,
                           output int lat, output logic saw_brd);
    int t_brd;
    int t_ack;
    t_brd = -1; t_ack = -1; saw_brd = 1'b0;
    @(negedge clk);
    addr = a; wr_n = ~wr; dat_i = wd;
    as_n = 1'b0; ds_n = ~ds;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (brd_en && t_brd < 0) begin t_brd = i; saw_brd = 1'b1; end
      if (!ack_n) begin t_ack = i; break; end
    end
    got_ack = (t_ack >= 0);
    lat = t_ack - t_brd;
  endtask

  task automatic end_cyc();
    @(negedge clk);
    ds_n = 2'b11;
    cyc(1);
    as_n = 1'b1;
    cyc(8);
  endtask

  initial begin : watchdog
    #(20ns * 100000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin : main
    logic got; int lat; logic sb;
    cyc(4);
    // R1: values during reset
    chk("R1 ack_n in reset", ack_n, 1);
    chk("R1 brd_en in reset", brd_en, 0);
    @(negedge clk); rst = 1'b0;
    cyc(3);
    chk("R1 ack_n after reset", ack_n, 1);
    chk("R1 brd_en after reset", brd_en, 0);
    chk("R1 selects after reset", {dma_cs, tlc_cs}, 0);
    chk("R1 cfg1 after reset", cfg1, 8'h00);
    chk("R1 cfg2 after reset", cfg2, 8'h00);

    // table walk: R3 R4 R5 R7 R8 R9 R10
    foreach (TAB[i]) begin
      start_cyc(TAB[i].a, TAB[i].ds, TAB[i].wr, TAB[i].wd, got, lat, sb);
      chk($sformatf("R3 vec%0d brd_en", i), sb, TAB[i].e_brd);
      chk($sformatf("R10 vec%0d ack", i), got, TAB[i].e_ack);
      chk($sformatf("R4 vec%0d dma_cs", i), dma_cs, TAB[i].e_sel == 2'd1);
      chk($sformatf("R5 vec%0d tlc_cs", i), tlc_cs, TAB[i].e_sel == 2'd2);
      if (got) begin
        chk($sformatf("R9 vec%0d ack latency", i), lat, 1);
        if (!TAB[i].wr)
          chk($sformatf("R8 vec%0d read data", i), dat_o, TAB[i].e_rd);
        if (TAB[i].e_sel == 2'd1) begin
          chk($sformatf("R4 vec%0d dma_reg", i), dma_reg, TAB[i].a[6:0]);
          chk($sformatf("R4 vec%0d lanes", i), dma_lanes, TAB[i].ds);
          chk($sformatf("R4 vec%0d dma_wr", i), dma_wr, TAB[i].wr);
        end
        if (TAB[i].e_sel == 2'd2)
          chk($sformatf("R5 vec%0d tlc_rs", i), tlc_rs, TAB[i].a[2:0]);
      end
      end_cyc();
      chk($sformatf("R7 vec%0d cfg1", i), cfg1, TAB[i].e_c1);
      chk($sformatf("R7 vec%0d cfg2", i), cfg2, TAB[i].e_c2);
    end

    // R2: address change mid-cycle is ignored
    start_cyc({BASE, 8'h12}, 2'b11, 1'b0, 16'h0, got, lat, sb);
    addr = {BASE, 8'h35};
    cyc(5);
    chk("R2 dma_reg held", dma_reg, 7'h12);
    chk("R2 dma_cs held", dma_cs, 1);
    // R9: ack held while strobes low
    chk("R9 ack held", ack_n, 0);
    @(negedge clk); ds_n = 2'b11;
    cyc(5);
    chk("R9 ack released", ack_n, 1);
    // R11: brd_en held while address strobe low
    chk("R11 brd_en held", brd_en, 1);
    as_n = 1'b1;
    cyc(5);
    chk("R11 brd_en released", brd_en, 0);

    // R6: override during a talker/listener read
    start_cyc({BASE, 8'h8A}, 2'b01, 1'b0, 16'h0, got, lat, sb);
    chk("R6 plain rs", tlc_rs, 3'd2);
    chk("R6 plain wr", tlc_wr, 0);
    aux_force = 1'b1;
    cyc(2);
    chk("R6 forced rs", tlc_rs, 3'd5);
    chk("R6 forced wr", tlc_wr, 1);
    aux_force = 1'b0;
    cyc(2);
    chk("R6 rs restored", tlc_rs, 3'd2);
    end_cyc();

    // R1: reset clears written configuration registers
    @(negedge clk); rst = 1'b1;
    cyc(3);
    @(negedge clk); rst = 1'b0;
    cyc(2);
    chk("R1 cfg1 cleared", cfg1, 8'h00);
    chk("R1 cfg2 cleared", cfg2, 8'h00);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule